// File: doc/BRIEF.md
# SD Card Command Issue Engine

This block is the command front end of an SD card host controller. Software programs a 32-bit argument and then writes a command word. The command word carries the 6-bit command index, the expected response kind, an optional wait for the card to release its busy signal, and two data-direction flags. Setting the start bit in that word launches the command. The engine serialises a 48-bit command frame, protected by CRC7, onto the CMD line. It then collects a short (48-bit) response, a long (136-bit) response, or no response at all.

The outcome is reported in two places. The start bit in the command register drops when the command is finished, and a separate fail bit in the same register marks an unsuccessful command. A write-one-to-clear status register gives the cause of a failure and records busy release. The engine moves one bit per clock cycle, so the card clock is the block clock, gated outside this block. The data path, card clock division and pad timing are handled elsewhere.

Top module: `sdcmd_engine`

## Requirements
- R1: Register map by word address: 0 command word, 1 argument, 2..5 response words, 6 status. In the command word, bits [5:0] hold the index, bit 6 the read-data flag, bit 7 the write-data flag, bit 9 long response, bit 10 no response, bit 11 busy wait, bit 14 fail (set by the engine) and bit 15 new/start. These fields read back as written and all other bits read as zero. After reset every register reads zero.
- R2: A command frame is 48 bits, sent MSB first on `cmdOut` while `cmdOe` is high: a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument, a 7-bit CRC (polynomial x^7+x^3+1, computed over the first 40 bits) and a 1 end bit. When `cmdOe` is low, `cmdOut` is high.
- R3: Writing the command word with bit 15 set starts a command. Bit 15 reads 1 until the command ends and is then cleared by hardware. With bit 10 set, the command ends right after its frame and no response is awaited.
- R4: A short response is 48 bits beginning with a 0 start bit. Its 32-bit card field (response bits 39:8) appears in response word 0, and words 1..3 read zero.
- R5: A long response is 136 bits. The 128 bits that follow its 8-bit header are stored so that word k (address 2+k) holds bits 32k+31:32k.
- R6: If no start bit appears on `cmdIn` within RSP_TIMEOUT (64) clock cycles after the frame, the engine sets status bit 6 and the fail bit, then clears bit 15. It does not end the command before that.
- R7: If the received CRC7 of a short response does not match the CRC computed over its first 40 bits, the engine sets status bit 4 and the fail bit.
- R8: With busy wait requested, bit 15 stays set after the response while `dat0In` is low. Once `dat0In` is high, the engine sets status bit 10 and clears bit 15.
- R9: A command word with both long response and busy wait set is rejected. No frame is driven, the fail bit is set, bit 15 is cleared and the status register is left unchanged.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: A write to the command word while bit 15 is set has no effect.
- R12: Starting a new command clears the fail bit left by an earlier one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, one card bit per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| cmdOut | output | 1 | CMD line value to the pad |
| cmdOe | output | 1 | CMD line drive enable |
| cmdIn | input | 1 | CMD line value from the card |
| dat0In | input | 1 | DAT0 line value, low while the card is busy |

## Verification
The checker watches, on every cycle, the properties that hold without reference to a whole exchange. These are: the start and end bits at the edges of each frame, the idle-high line, no drive without a pending command, every timeout or CRC flag arriving together with the fail bit and a finished command, busy release following a high DAT0, no frame for the rejected combination, and command writes being held off while a command is pending. The directed scenarios are the only way to show the exact frame contents and CRC against known-good frames, response word placement for both lengths, the timeout window, and the write-one-to-clear behaviour of individual status bits.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int ADDR_W       = 3;
  localparam int REG_W        = 32;
  localparam int IDX_W        = 6;
  localparam int CRC_W        = 7;
  localparam int STAT_W       = 11;
  localparam int FRAME_W      = 48;
  localparam int CRC_SPAN     = FRAME_W - CRC_W - 1;
  localparam int RX_SHORT_W   = FRAME_W - 1;
  localparam int RX_LONG_W    = 135;
  localparam int RSP_W        = 128;
  localparam int RSP_WORDS    = RSP_W / REG_W;

  localparam logic [ADDR_W-1:0] ADDR_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_ARG  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RSP0 = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd6;

  localparam int B_RD    = 6;
  localparam int B_WR    = 7;
  localparam int B_LONG  = 9;
  localparam int B_NORSP = 10;
  localparam int B_BUSY  = 11;
  localparam int B_FAIL  = 14;
  localparam int B_NEW   = 15;

  localparam int S_CRC7  = 4;
  localparam int S_CTOUT = 6;
  localparam int S_BUSYD = 10;
  localparam logic [STAT_W-1:0] STAT_MASK =
    STAT_W'((1 << S_CRC7) | (1 << S_CTOUT) | (1 << S_BUSYD));

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_WAIT, ST_RECV, ST_CHECK, ST_BUSY
  } ctlState_t;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic shiftRx;
    logic latchRsp;
    logic setTimeout;
    logic setCrcErr;
    logic setBusyDone;
    logic setFail;
    logic finish;
  } ctlStrobe_t;

  function automatic logic [CRC_W-1:0] crc7Calc(input logic [CRC_SPAN-1:0] bits);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = CRC_SPAN - 1; i >= 0; i--) begin
      fb = bits[i] ^ c[CRC_W-1];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_dp.sv
module sdcmd_dp
  import sdcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              cmdIn,
  input  ctlStrobe_t        strobe,
  output logic              cmdNew,
  output logic              cmdFail,
  output logic              isLong,
  output logic              noResp,
  output logic              busyWait,
  output logic              comboBad,
  output logic              crcOk,
  output logic              txBit,
  output logic [IDX_W-1:0]  cmdIdx,
  output logic [STAT_W-1:0] statusQ
);

  logic [IDX_W-1:0]     idxQ;
  logic                 rdQ, wrQ, longQ, noRspQ, busyQ, newQ, failQ;
  logic [REG_W-1:0]     argQ;
  logic [RSP_W-1:0]     rspQ;
  logic [STAT_W-1:0]    statQ;
  logic [FRAME_W-1:0]   txQ;
  logic [RX_LONG_W-1:0] rxQ;

  logic                 cmdWrite;
  logic [STAT_W-1:0]    statSet, statClr;
  logic [CRC_SPAN-1:0]  txHead;

  assign cmdWrite = regWrEn && (regAddr == ADDR_CMD) && !newQ;
  assign txHead   = {2'b01, idxQ, argQ};

  // Command word fields, start and fail bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ   <= '0;
      rdQ    <= 1'b0;
      wrQ    <= 1'b0;
      longQ  <= 1'b0;
      noRspQ <= 1'b0;
      busyQ  <= 1'b0;
      newQ   <= 1'b0;
      failQ  <= 1'b0;
    end else begin
      if (cmdWrite) begin
        idxQ   <= regWrData[IDX_W-1:0];
        rdQ    <= regWrData[B_RD];
        wrQ    <= regWrData[B_WR];
        longQ  <= regWrData[B_LONG];
        noRspQ <= regWrData[B_NORSP];
        busyQ  <= regWrData[B_BUSY];
        newQ   <= regWrData[B_NEW];
        if (regWrData[B_NEW]) failQ <= 1'b0;
      end
      if (strobe.setFail) failQ <= 1'b1;
      if (strobe.finish)  newQ  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) argQ <= '0;
    else if (regWrEn && regAddr == ADDR_ARG) argQ <= regWrData;
  end

  // Status: hardware set wins over a same-cycle clear
  always_comb begin
    statSet = '0;
    statSet[S_CRC7]  = strobe.setCrcErr;
    statSet[S_CTOUT] = strobe.setTimeout;
    statSet[S_BUSYD] = strobe.setBusyDone;
    statClr = (regWrEn && regAddr == ADDR_STAT) ? regWrData[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= ((statQ & ~statClr) | statSet) & STAT_MASK;
  end

  // Transmit shifter: frame built in parallel, sent MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txQ <= '1;
    else if (strobe.loadTx)  txQ <= {txHead, crc7Calc(txHead), 1'b1};
    else if (strobe.shiftTx) txQ <= {txQ[FRAME_W-2:0], 1'b1};
  end

  // Receive shifter: everything after the start bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxQ <= '0;
    else if (strobe.shiftRx) rxQ <= {rxQ[RX_LONG_W-2:0], cmdIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspQ <= '0;
    else if (strobe.latchRsp) begin
      if (longQ) rspQ <= rxQ[RSP_W-1:0];
      else       rspQ <= {{(RSP_W-REG_W){1'b0}}, rxQ[REG_W+CRC_W:CRC_W+1]};
    end
  end

  assign crcOk = (crc7Calc({1'b0, rxQ[RX_SHORT_W-1:CRC_W+1]}) == rxQ[CRC_W:1]);

  // Register read mux
  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_CMD) begin
      regRdData[IDX_W-1:0] = idxQ;
      regRdData[B_RD]      = rdQ;
      regRdData[B_WR]      = wrQ;
      regRdData[B_LONG]    = longQ;
      regRdData[B_NORSP]   = noRspQ;
      regRdData[B_BUSY]    = busyQ;
      regRdData[B_FAIL]    = failQ;
      regRdData[B_NEW]     = newQ;
    end
    if (regAddr == ADDR_ARG)  regRdData = argQ;
    if (regAddr == ADDR_STAT) regRdData[STAT_W-1:0] = statQ;
    for (int k = 0; k < RSP_WORDS; k++) begin
      if (regAddr == ADDR_RSP0 + ADDR_W'(k)) regRdData = rspQ[k*REG_W +: REG_W];
    end
  end

  assign cmdNew   = newQ;
  assign cmdFail  = failQ;
  assign isLong   = longQ;
  assign noResp   = noRspQ;
  assign busyWait = busyQ;
  assign comboBad = longQ && busyQ;
  assign txBit    = txQ[FRAME_W-1];
  assign cmdIdx   = idxQ;
  assign statusQ  = statQ;

endmodule

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int RSP_TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdNew,
  input  logic       comboBad,
  input  logic       noResp,
  input  logic       isLong,
  input  logic       busyWait,
  input  logic       crcOk,
  input  logic       cmdIn,
  input  logic       dat0In,
  output ctlStrobe_t strobe,
  output logic       cmdOe
);

  localparam int CNT_MAX = (RSP_TIMEOUT > RX_LONG_W) ? RSP_TIMEOUT : RX_LONG_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LAST_TX    = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] LAST_WAIT  = CNT_W'(RSP_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(RX_SHORT_W - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(RX_LONG_W - 1);

  ctlState_t        stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic [CNT_W-1:0] lastRx;

  assign lastRx = isLong ? LAST_LONG : LAST_SHORT;
  assign cmdOe  = (stateQ == ST_SEND);

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    cntD   = cntQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (cmdNew) begin
          if (comboBad) begin
            strobe.setFail = 1'b1;
            strobe.finish  = 1'b1;
          end else begin
            strobe.loadTx = 1'b1;
            stateD        = ST_SEND;
            cntD          = '0;
          end
        end
      end
      ST_SEND: begin
        strobe.shiftTx = 1'b1;
        cntD           = cntQ + 1'b1;
        if (cntQ == LAST_TX) begin
          cntD = '0;
          if (noResp) begin
            strobe.finish = 1'b1;
            stateD        = ST_IDLE;
          end else begin
            stateD = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (!cmdIn) begin
          stateD = ST_RECV;
          cntD   = '0;
        end else if (cntQ == LAST_WAIT) begin
          strobe.setTimeout = 1'b1;
          strobe.setFail    = 1'b1;
          strobe.finish     = 1'b1;
          stateD            = ST_IDLE;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_RECV: begin
        strobe.shiftRx = 1'b1;
        cntD           = cntQ + 1'b1;
        if (cntQ == lastRx) stateD = ST_CHECK;
      end
      ST_CHECK: begin
        strobe.latchRsp = 1'b1;
        if (!isLong && !crcOk) begin
          strobe.setCrcErr = 1'b1;
          strobe.setFail   = 1'b1;
          strobe.finish    = 1'b1;
          stateD           = ST_IDLE;
        end else if (busyWait) begin
          stateD = ST_BUSY;
        end else begin
          strobe.finish = 1'b1;
          stateD        = ST_IDLE;
        end
      end
      ST_BUSY: begin
        if (dat0In) begin
          strobe.setBusyDone = 1'b1;
          strobe.finish      = 1'b1;
          stateD             = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int RSP_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              cmdOut,
  output logic              cmdOe,
  input  logic              cmdIn,
  input  logic              dat0In
);

  ctlStrobe_t        strobe;
  logic              cmdNew, cmdFail, isLong, noResp, busyWait, comboBad, crcOk, txBit;
  logic [IDX_W-1:0]  cmdIdx;
  logic [STAT_W-1:0] statusQ;

  sdcmd_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .cmdIn     (cmdIn),
    .strobe    (strobe),
    .cmdNew    (cmdNew),
    .cmdFail   (cmdFail),
    .isLong    (isLong),
    .noResp    (noResp),
    .busyWait  (busyWait),
    .comboBad  (comboBad),
    .crcOk     (crcOk),
    .txBit     (txBit),
    .cmdIdx    (cmdIdx),
    .statusQ   (statusQ)
  );

  sdcmd_ctrl #(.RSP_TIMEOUT(RSP_TIMEOUT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdNew   (cmdNew),
    .comboBad (comboBad),
    .noResp   (noResp),
    .isLong   (isLong),
    .busyWait (busyWait),
    .crcOk    (crcOk),
    .cmdIn    (cmdIn),
    .dat0In   (dat0In),
    .strobe   (strobe),
    .cmdOe    (cmdOe)
  );

  assign cmdOut = cmdOe ? txBit : 1'b1;

endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk
  import sdcmd_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              cmdOut,
  input logic              cmdOe,
  input logic              dat0In,
  input logic              cmdNew,
  input logic              cmdFail,
  input logic              isLong,
  input logic              busyWait,
  input logic [IDX_W-1:0]  cmdIdx,
  input logic [STAT_W-1:0] statusQ
);

  AST_FRAME_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdOe) |-> !cmdOut); // R2
  AST_FRAME_END_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdOe) |-> $past(cmdOut)); // R2
  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !cmdOe |-> cmdOut); // R2
  AST_DRIVE_NEEDS_NEW: assert property (@(posedge clk) disable iff (!rstN)
    cmdOe |-> cmdNew); // R3
  AST_TIMEOUT_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[S_CTOUT]) |-> (cmdFail && !cmdNew)); // R6
  AST_CRC_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[S_CRC7]) |-> (cmdFail && !cmdNew)); // R7
  AST_BUSY_AFTER_DAT0: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[S_BUSYD]) |-> ($past(dat0In) && !cmdNew)); // R8
  AST_COMBO_NO_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (cmdNew && isLong && busyWait) |-> !cmdOe); // R9
  AST_HELD_WHILE_NEW: assert property (@(posedge clk) disable iff (!rstN)
    (cmdNew && regWrEn && regAddr == ADDR_CMD) |=> (cmdIdx == $past(cmdIdx))); // R11

endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .cmdOut   (cmdOut),
  .cmdOe    (cmdOe),
  .dat0In   (dat0In),
  .cmdNew   (cmdNew),
  .cmdFail  (cmdFail),
  .isLong   (isLong),
  .busyWait (busyWait),
  .cmdIdx   (cmdIdx),
  .statusQ  (statusQ)
);

// File: tb/sim_sdcmd_engine.sv
`timescale 1ns/1ps
module sim_sdcmd_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cmdOut, cmdOe;
  logic        cmdIn = 1'b1;
  logic        dat0In = 1'b1;

  int nChk = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  sdcmd_engine u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cmdOut(cmdOut),
    .cmdOe(cmdOe), .cmdIn(cmdIn), .dat0In(dat0In)
  );

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitDone(input string req, output logic [31:0] word);
    bit done = 0;
    for (int t = 0; t < 500; t++) begin
      regRd(3'd0, word);
      if (!word[15]) begin done = 1; break; end
    end
    if (!done) check(req, "command never finished", 1, 0);
  endtask

  // Remainder of division by x^7+x^3+1 (0x89)
  function automatic logic [6:0] benchCrc(input logic [39:0] b);
    logic [46:0] r;
    r = {b, 7'b0};
    for (int i = 46; i >= 7; i--) if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  function automatic logic [135:0] mkShort(input logic [5:0] idx, input logic [31:0] d,
                                           input bit corrupt);
    logic [6:0] c;
    c = benchCrc({2'b00, idx, d}) ^ (corrupt ? 7'h01 : 7'h00);
    return {88'b0, 2'b00, idx, d, c, 1'b1};
  endfunction

  // Card model: captures the frame, then optionally replies
  task automatic card(input int gap, input bit respond, input int rLen,
                      input logic [135:0] rBits, output logic [47:0] frame,
                      output bit seen);
    seen = 0;
    frame = '0;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (cmdOe) begin seen = 1; break; end
    end
    if (!seen) return;
    for (int i = 0; i < 48; i++) begin
      frame = {frame[46:0], cmdOut};
      @(negedge clk);
    end
    if (respond) begin
      repeat (gap) @(negedge clk);
      for (int i = 0; i < rLen; i++) begin
        cmdIn = rBits[rLen-1-i];
        @(negedge clk);
      end
      cmdIn = 1'b1;
    end
  endtask

  task automatic tReset();
    logic [31:0] d;
    for (int a = 0; a < 7; a++) begin
      regRd(3'(a), d);
      check("R1", $sformatf("reset value addr %0d", a), d, 0);
    end
    check("R2", "idle cmdOe", cmdOe, 0);
    check("R2", "idle cmdOut", cmdOut, 1);
  endtask

  task automatic tNoResponse();
    logic [47:0] f; bit seen; logic [31:0] w;
    regWr(3'd1, 32'h0);
    regWr(3'd0, 32'h0000_8400);
    card(0, 0, 0, '0, f, seen);
    check("R2", "CMD0 frame seen", seen, 1);
    check("R2", "CMD0 frame with CRC", f, 48'h40_0000_0000_95);
    waitDone("R3", w);
    check("R3", "no-response command word after finish", w, 32'h0000_0400);
  endtask

  task automatic tShort();
    logic [47:0] f; bit seen; logic [31:0] w;
    regWr(3'd1, 32'h0000_01AA);
    regWr(3'd0, 32'h0000_8008);
    card(3, 1, 48, mkShort(6'd8, 32'hCAFE_01AA, 0), f, seen);
    check("R2", "CMD8 frame with CRC", f, 48'h48_0000_01AA_87);
    waitDone("R3", w);
    check("R3", "short command word after finish", w, 32'h0000_0008);
    regRd(3'd2, w); check("R4", "short response word 0", w, 32'hCAFE_01AA);
    regRd(3'd3, w); check("R4", "short response word 1", w, 0);
    regRd(3'd6, w); check("R7", "no error on good CRC", w, 0);
  endtask

  task automatic tReadFlag();
    logic [47:0] f; bit seen; logic [31:0] w;
    regWr(3'd1, 32'h0000_0200);
    regWr(3'd0, 32'h0000_8051);
    card(1, 1, 48, mkShort(6'd17, 32'h0000_0900, 0), f, seen);
    check("R2", "CMD17 frame header", f[47:8], {2'b01, 6'd17, 32'h0000_0200});
    check("R2", "CMD17 frame CRC", f[7:0], {benchCrc({2'b01, 6'd17, 32'h200}), 1'b1});
    waitDone("R1", w);
    check("R1", "read flag readback", w, 32'h0000_0051);
  endtask

  task automatic tLong();
    logic [47:0] f; bit seen; logic [31:0] w;
    logic [127:0] pay;
    pay = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211;
    regWr(3'd0, 32'h0000_8202);
    card(2, 1, 136, {2'b00, 6'h3F, pay}, f, seen);
    waitDone("R5", w);
    check("R5", "long command word", w, 32'h0000_0202);
    for (int k = 0; k < 4; k++) begin
      regRd(3'(2 + k), w);
      check("R5", $sformatf("long response word %0d", k), w, pay[32*k +: 32]);
    end
  endtask

  task automatic tCrcBad();
    logic [47:0] f; bit seen; logic [31:0] w;
    regWr(3'd0, 32'h0000_800D);
    card(2, 1, 48, mkShort(6'd13, 32'h0000_0700, 1), f, seen);
    waitDone("R7", w);
    check("R7", "fail bit on CRC error", w, 32'h0000_400D);
    regRd(3'd6, w); check("R7", "CRC7 status bit", w, 32'h10);
    regWr(3'd6, 32'h10);
    regRd(3'd6, w); check("R10", "CRC7 bit cleared", w, 0);
    // next good command clears the stale fail bit
    regWr(3'd0, 32'h0000_8008);
    card(2, 1, 48, mkShort(6'd8, 32'h1111_2222, 0), f, seen);
    waitDone("R12", w);
    check("R12", "fail cleared by new command", w, 32'h0000_0008);
  endtask

  task automatic tTimeout();
    logic [47:0] f; bit seen; logic [31:0] w;
    regWr(3'd0, 32'h0000_8005);
    card(0, 0, 0, '0, f, seen);
    repeat (40) @(negedge clk);
    regRd(3'd0, w); check("R6", "still pending inside window", w[15], 1);
    waitDone("R6", w);
    check("R6", "fail bit on timeout", w, 32'h0000_4005);
    regRd(3'd6, w); check("R6", "timeout status bit", w, 32'h40);
    regWr(3'd6, 32'h10);
    regRd(3'd6, w); check("R10", "unrelated clear leaves bit", w, 32'h40);
    regWr(3'd6, 32'h40);
    regRd(3'd6, w); check("R10", "timeout bit cleared", w, 0);
  endtask

  task automatic tBusy();
    logic [47:0] f; bit seen; logic [31:0] w;
    dat0In = 1'b0;
    regWr(3'd0, 32'h0000_8807);
    card(2, 1, 48, mkShort(6'd7, 32'h0000_0C00, 0), f, seen);
    repeat (5) @(negedge clk);
    regRd(3'd0, w); check("R8", "pending while DAT0 low", w, 32'h0000_8807);
    regRd(3'd6, w); check("R8", "no busy-done yet", w, 0);
    regWr(3'd0, 32'h0000_8011);
    regRd(3'd0, w); check("R11", "write ignored while pending", w, 32'h0000_8807);
    dat0In = 1'b1;
    waitDone("R8", w);
    check("R8", "finished after DAT0 release", w, 32'h0000_0807);
    regRd(3'd6, w); check("R8", "busy-done status bit", w, 32'h400);
    regWr(3'd6, 32'h400);
  endtask

  task automatic tCombo();
    logic [47:0] f; bit seen; logic [31:0] w;
    regWr(3'd0, 32'h0000_8A03);
    card(0, 0, 0, '0, f, seen);
    check("R9", "no frame for long+busy", seen, 0);
    waitDone("R9", w);
    check("R9", "rejected command word", w, 32'h0000_4A03);
    regRd(3'd6, w); check("R9", "status untouched", w, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL R3 watchdog: got hung expected finished run");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tNoResponse();
    tShort();
    tReadFlag();
    tLong();
    tCrcBad();
    tTimeout();
    tBusy();
    tCombo();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule